// File: doc/BRIEF.md
# Floating-Point Rounding and Exception State Unit

This unit holds the floating-point control and status state of a scalar core. There are two fields: five sticky exception flags and a three-bit rounding mode. Together they also form one 8-bit combined register. Software reaches this state through three aliased register addresses. Each access returns the addressed field's prior contents and then applies a write, bit-set or bit-clear to that field. The operand comes either from a register value or from a 5-bit immediate taken from the instruction.

The arithmetic side uses the unit in two ways. An instruction may carry the "dynamic" rounding code, and the unit resolves that code into the stored rounding mode. Each completed floating-point operation reports its exception flags, and the unit ORs them into the stored flag field, where they stay until software clears them. An address the unit does not know, or the reserved operation code, is flagged as illegal and changes nothing. Decoding, privilege checking and the arithmetic datapath belong to other blocks.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset both fields are zero: the combined view reads 0x00, and a dynamic rounding request resolves to 0 (round to nearest, ties to even).
- R2: In the combined 8-bit view, bits 4:0 are the exception flags and bits 7:5 are the rounding mode.
- R3: Address 0x001 selects the flags alone, 0x002 the rounding mode alone and 0x003 the combined register. Read data is the selected field zero-extended to XLEN.
- R4: The read data of a legal access is combinational and shows the field's value before that access. The modification takes effect at the next rising clock edge.
- R5: Operation code 0 (write) replaces the field with the operand. The operand is truncated to the field's width.
- R6: Operation code 1 (set) ORs the operand into the field.
- R7: Operation code 2 (clear) ANDs the field with the complement of the operand.
- R8: When the immediate select is high, the operand is the 5-bit immediate, zero-extended, and the register operand is ignored.
- R9: An access through the flags view or the rounding-mode view leaves the other field unchanged.
- R10: A request to any other address, or one with operation code 3, raises the illegal output, returns zero and leaves both fields unchanged.
- R11: When the instruction's rounding code is 7, the effective rounding mode is the stored rounding mode. Any other code passes through unchanged.
- R12: When the completion strobe is high, the reported flags are ORed into the stored flags. Accrued flags never clear on their own. Flags reported while the strobe is low are ignored.
- R13: If a register access and a flag accrual fall in the same cycle, the access result is formed first and the accrued flags are ORed on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Register access request |
| acc_addr | input | ADDR_W | Register address |
| acc_op | input | 2 | 0 write, 1 set, 2 clear, 3 reserved |
| acc_use_imm | input | 1 | Take the operand from the immediate |
| acc_reg_val | input | XLEN | Register operand |
| acc_imm | input | UIMM_W | Immediate operand |
| acc_rdata | output | XLEN | Prior value of the addressed field |
| acc_illegal | output | 1 | Unknown address or reserved operation |
| insn_rm | input | 3 | Rounding code carried by the instruction |
| eff_rm | output | 3 | Resolved rounding mode |
| fpu_done | input | 1 | A floating-point operation completed |
| fpu_flags | input | 5 | Exception flags raised by that operation |

## Verification
A software access and a flag accrual from the datapath can land on the same clock edge, and both modify the flag field. The bench forces this collision by raising the completion strobe in the same cycle as a write, a clear and a combined-view write. It then reads the flags back and expects the access result ORed with the reported flags. A clear that covers every flag, for example, must still leave the bits just accrued.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
   localparam int FLAG_W = 5;
   localparam int RM_W   = 3;
   localparam int FCSR_W = FLAG_W + RM_W;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_RSVD  = 2'd3
   } acc_op_e;

   typedef enum logic [1:0] {
      VIEW_NONE  = 2'd0,
      VIEW_FLAGS = 2'd1,
      VIEW_RM    = 2'd2,
      VIEW_ALL   = 2'd3
   } acc_view_e;

   typedef struct packed {
      logic [RM_W-1:0]   rm;
      logic [FLAG_W-1:0] flags;
   } fcsr_t;
endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
   import fpcsr_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int ADDR_FLAGS = 1,
   parameter int ADDR_RM    = 2,
   parameter int ADDR_ALL   = 3
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        op,
   output acc_view_e         view,
   output logic              illegal,
   output logic              commit
);
   initial begin
      if (ADDR_FLAGS == ADDR_RM || ADDR_FLAGS == ADDR_ALL || ADDR_RM == ADDR_ALL)
         $error("fpcsr_decode: register addresses must differ");
      if (ADDR_W < 2) $error("fpcsr_decode: ADDR_W too small");
   end

   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADDR_FLAGS);
   localparam logic [ADDR_W-1:0] A_RM    = ADDR_W'(ADDR_RM);
   localparam logic [ADDR_W-1:0] A_ALL   = ADDR_W'(ADDR_ALL);

   always_comb begin
      view = VIEW_NONE;
      if (addr == A_FLAGS)    view = VIEW_FLAGS;
      else if (addr == A_RM)  view = VIEW_RM;
      else if (addr == A_ALL) view = VIEW_ALL;
   end

   always_comb begin
      illegal = req && ((view == VIEW_NONE) || (acc_op_e'(op) == OP_RSVD));
      commit  = req && !illegal;
   end
endmodule

// File: rtl/fpcsr_rmw.sv
module fpcsr_rmw
   import fpcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int UIMM_W = 5
) (
   input  fcsr_t             cur,
   input  acc_view_e         view,
   input  logic [1:0]        op,
   input  logic              commit,
   input  logic              use_imm,
   input  logic [XLEN-1:0]   reg_val,
   input  logic [UIMM_W-1:0] imm,
   output logic [XLEN-1:0]   old_val,
   output fcsr_t             nxt
);
   initial begin
      if (XLEN < FCSR_W) $error("fpcsr_rmw: XLEN must hold the combined register");
      if (UIMM_W > XLEN) $error("fpcsr_rmw: immediate wider than XLEN");
   end

   localparam logic [FCSR_W-1:0] MASK_FLAGS = FCSR_W'((1 << FLAG_W) - 1);
   localparam logic [FCSR_W-1:0] MASK_RM    = FCSR_W'((1 << RM_W) - 1);
   localparam logic [FCSR_W-1:0] MASK_ALL   = {FCSR_W{1'b1}};

   logic [XLEN-1:0]   operand;
   logic [FCSR_W-1:0] opnd8;
   logic [FCSR_W-1:0] old8;
   logic [FCSR_W-1:0] mask8;
   logic [FCSR_W-1:0] mod8;

   always_comb begin
      operand = use_imm ? XLEN'(imm) : reg_val;
      opnd8   = operand[FCSR_W-1:0];
   end

   always_comb begin
      unique case (view)
         VIEW_FLAGS: begin old8 = FCSR_W'(cur.flags); mask8 = MASK_FLAGS; end
         VIEW_RM:    begin old8 = FCSR_W'(cur.rm);    mask8 = MASK_RM;    end
         VIEW_ALL:   begin old8 = cur;                mask8 = MASK_ALL;   end
         default:    begin old8 = '0;                 mask8 = '0;         end
      endcase
   end

   for (genvar b = 0; b < FCSR_W; b++) begin : g_bit
      always_comb begin
         unique case (acc_op_e'(op))
            OP_WRITE: mod8[b] = opnd8[b] & mask8[b];
            OP_SET:   mod8[b] = (old8[b] | opnd8[b]) & mask8[b];
            OP_CLEAR: mod8[b] = old8[b] & ~opnd8[b] & mask8[b];
            default:  mod8[b] = old8[b];
         endcase
      end
   end

   always_comb begin
      nxt = cur;
      if (commit) begin
         unique case (view)
            VIEW_FLAGS: nxt.flags = mod8[FLAG_W-1:0];
            VIEW_RM:    nxt.rm    = mod8[RM_W-1:0];
            VIEW_ALL:   nxt       = mod8;
            default:    nxt       = cur;
         endcase
      end
      old_val = commit ? XLEN'(old8) : '0;
   end
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve #(
   parameter int RM_BITS  = 3,
   parameter int DYN_CODE = 7
) (
   input  logic [RM_BITS-1:0] insn_rm,
   input  logic [RM_BITS-1:0] stored_rm,
   output logic [RM_BITS-1:0] eff_rm
);
   initial begin
      if (DYN_CODE >= (1 << RM_BITS)) $error("fpcsr_rm_resolve: dynamic code out of range");
   end

   localparam logic [RM_BITS-1:0] DYN = RM_BITS'(DYN_CODE);

   always_comb eff_rm = (insn_rm == DYN) ? stored_rm : insn_rm;
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int ADDR_W     = 12,
   parameter int UIMM_W     = 5,
   parameter int ADDR_FLAGS = 1,
   parameter int ADDR_RM    = 2,
   parameter int ADDR_ALL   = 3,
   parameter int DYN_CODE   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_op,
   input  logic              acc_use_imm,
   input  logic [XLEN-1:0]   acc_reg_val,
   input  logic [UIMM_W-1:0] acc_imm,
   output logic [XLEN-1:0]   acc_rdata,
   output logic              acc_illegal,
   input  logic [2:0]        insn_rm,
   output logic [2:0]        eff_rm,
   input  logic              fpu_done,
   input  logic [4:0]        fpu_flags
);
   initial begin
      if (RM_W != 3 || FLAG_W != 5) $error("fpcsr_unit: field widths disagree with ports");
   end

   fcsr_t     state_q;
   fcsr_t     acc_nxt;
   fcsr_t     state_d;
   acc_view_e view;
   logic      commit;

   fpcsr_decode #(
      .ADDR_W(ADDR_W), .ADDR_FLAGS(ADDR_FLAGS), .ADDR_RM(ADDR_RM), .ADDR_ALL(ADDR_ALL)
   ) u_decode (
      .req(acc_req), .addr(acc_addr), .op(acc_op),
      .view(view), .illegal(acc_illegal), .commit(commit)
   );

   fpcsr_rmw #(.XLEN(XLEN), .UIMM_W(UIMM_W)) u_rmw (
      .cur(state_q), .view(view), .op(acc_op), .commit(commit),
      .use_imm(acc_use_imm), .reg_val(acc_reg_val), .imm(acc_imm),
      .old_val(acc_rdata), .nxt(acc_nxt)
   );

   fpcsr_rm_resolve #(.RM_BITS(RM_W), .DYN_CODE(DYN_CODE)) u_rm (
      .insn_rm(insn_rm), .stored_rm(state_q.rm), .eff_rm(eff_rm)
   );

   // accrued flags are applied after the access result
   always_comb begin
      state_d = acc_nxt;
      if (fpu_done) state_d.flags = acc_nxt.flags | fpu_flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end

   // R10
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_illegal && !fpu_done) |=> $stable(state_q));

   // R10
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_illegal |-> (acc_rdata == '0));

   // R12
   accrue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fpu_done |=> ((state_q.flags & $past(fpu_flags)) == $past(fpu_flags)));

   // R12
   flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> ((state_q.flags & $past(state_q.flags)) == $past(state_q.flags)));

   // R9
   rm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_req || acc_addr == ADDR_W'(ADDR_FLAGS)) |=> $stable(state_q.rm));

   // R11
   dyn_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_rm == 3'(DYN_CODE)) |-> (eff_rm == state_q.rm));
endmodule

// File: tb/fpcsr_unit_tb.sv
module fpcsr_unit_tb;
   localparam int XLEN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [1:0]  acc_op = '0;
   logic        acc_use_imm = 1'b0;
   logic [31:0] acc_reg_val = '0;
   logic [4:0]  acc_imm = '0;
   logic [31:0] acc_rdata;
   logic        acc_illegal;
   logic [2:0]  insn_rm = '0;
   logic [2:0]  eff_rm;
   logic        fpu_done = 1'b0;
   logic [4:0]  fpu_flags = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fpcsr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
      .acc_op(acc_op), .acc_use_imm(acc_use_imm), .acc_reg_val(acc_reg_val),
      .acc_imm(acc_imm), .acc_rdata(acc_rdata), .acc_illegal(acc_illegal),
      .insn_rm(insn_rm), .eff_rm(eff_rm), .fpu_done(fpu_done), .fpu_flags(fpu_flags)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one access cycle; returns read data and illegal sampled before the edge
   task automatic access(input logic [11:0] a, input logic [1:0] op, input logic imm_sel,
                         input logic [31:0] rv, input logic [4:0] iv,
                         input logic done, input logic [4:0] fl,
                         output logic [31:0] rd, output logic ill);
      @(negedge clk);
      acc_req = 1'b1; acc_addr = a; acc_op = op; acc_use_imm = imm_sel;
      acc_reg_val = rv; acc_imm = iv; fpu_done = done; fpu_flags = fl;
      #1;
      rd = acc_rdata; ill = acc_illegal;
      @(posedge clk);
      #1;
      acc_req = 1'b0; fpu_done = 1'b0; fpu_flags = '0; acc_use_imm = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] rd);
      logic ill;
      access(a, 2'd1, 1'b0, 32'h0, 5'h0, 1'b0, 5'h0, rd, ill);
   endtask

   task automatic t_reset;
      logic [31:0] rd;
      @(negedge clk);
      insn_rm = 3'd7; #1;
      check("R1 dyn rm after reset", 32'(eff_rm), 32'h0);
      check("R1 illegal idle", 32'(acc_illegal), 32'h0);
      rd_reg(12'h003, rd);
      check("R1 combined after reset", rd, 32'h0);
   endtask

   task automatic t_write_views;
      logic [31:0] rd; logic ill;
      access(12'h003, 2'd0, 1'b0, 32'hFFFF_FFA5, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R4 old value on combined write", rd, 32'h0);
      rd_reg(12'h003, rd); check("R5 truncated combined write", rd, 32'hA5);
      rd_reg(12'h001, rd); check("R2 R3 flags view", rd, 32'h05);
      rd_reg(12'h002, rd); check("R2 R3 rm view", rd, 32'h5);
      access(12'h002, 2'd0, 1'b0, 32'h3, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R4 old rm", rd, 32'h5);
      rd_reg(12'h003, rd); check("R9 rm write keeps flags", rd, 32'h65);
      access(12'h001, 2'd0, 1'b0, 32'hFFFF_FF1A, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R4 old flags", rd, 32'h05);
      rd_reg(12'h003, rd); check("R9 flags write keeps rm", rd, 32'h7A);
   endtask

   task automatic t_set_clear;
      logic [31:0] rd; logic ill;
      access(12'h001, 2'd1, 1'b0, 32'h04, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R6 set returns old", rd, 32'h1A);
      rd_reg(12'h001, rd); check("R6 set result", rd, 32'h1E);
      access(12'h001, 2'd2, 1'b0, 32'h0A, 5'h0, 1'b0, 5'h0, rd, ill);
      rd_reg(12'h001, rd); check("R7 clear result", rd, 32'h14);
      access(12'h003, 2'd2, 1'b0, 32'hE0, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R7 clear combined old", rd, 32'h74);
      rd_reg(12'h003, rd); check("R7 clear rm via combined", rd, 32'h14);
   endtask

   task automatic t_imm;
      logic [31:0] rd; logic ill;
      access(12'h002, 2'd0, 1'b1, 32'h0, 5'h1C, 1'b0, 5'h0, rd, ill);
      rd_reg(12'h002, rd); check("R8 R5 immediate rm write", rd, 32'h4);
      access(12'h001, 2'd1, 1'b1, 32'hFFFF_FFFF, 5'h03, 1'b0, 5'h0, rd, ill);
      check("R8 immediate set old", rd, 32'h14);
      rd_reg(12'h003, rd); check("R8 register operand ignored", rd, 32'h97);
   endtask

   task automatic t_illegal;
      logic [31:0] rd; logic ill;
      access(12'h004, 2'd0, 1'b0, 32'h0, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R10 unknown addr illegal", 32'(ill), 32'h1);
      check("R10 unknown addr rdata", rd, 32'h0);
      access(12'h000, 2'd2, 1'b0, 32'hFF, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R10 addr zero illegal", 32'(ill), 32'h1);
      access(12'h003, 2'd3, 1'b0, 32'h0, 5'h0, 1'b0, 5'h0, rd, ill);
      check("R10 reserved op illegal", 32'(ill), 32'h1);
      rd_reg(12'h003, rd); check("R10 state unchanged", rd, 32'h97);
   endtask

   task automatic t_rounding;
      logic [31:0] rd; logic ill;
      @(negedge clk); insn_rm = 3'd7; #1;
      check("R11 dynamic code uses stored", 32'(eff_rm), 32'h4);
      insn_rm = 3'd2; #1;
      check("R11 static code passes", 32'(eff_rm), 32'h2);
      access(12'h002, 2'd0, 1'b0, 32'h1, 5'h0, 1'b0, 5'h0, rd, ill);
      @(negedge clk); insn_rm = 3'd7; #1;
      check("R11 dynamic follows new rm", 32'(eff_rm), 32'h1);
   endtask

   task automatic t_accrue;
      logic [31:0] rd; logic ill;
      access(12'h001, 2'd0, 1'b0, 32'h0, 5'h0, 1'b0, 5'h0, rd, ill);
      @(negedge clk); fpu_done = 1'b1; fpu_flags = 5'h01;
      @(negedge clk); fpu_flags = 5'h08;
      @(negedge clk); fpu_done = 1'b0; fpu_flags = 5'h10;
      @(negedge clk); fpu_flags = 5'h0;
      rd_reg(12'h001, rd); check("R12 accrued and strobe gated", rd, 32'h09);
   endtask

   task automatic t_collide;
      logic [31:0] rd; logic ill;
      access(12'h001, 2'd0, 1'b0, 32'h02, 5'h0, 1'b1, 5'h10, rd, ill);
      check("R13 collide old value", rd, 32'h09);
      rd_reg(12'h001, rd); check("R13 write then accrue", rd, 32'h12);
      access(12'h001, 2'd2, 1'b0, 32'h1F, 5'h0, 1'b1, 5'h04, rd, ill);
      rd_reg(12'h001, rd); check("R13 clear then accrue", rd, 32'h04);
      access(12'h003, 2'd0, 1'b0, 32'h00, 5'h0, 1'b1, 5'h01, rd, ill);
      rd_reg(12'h003, rd); check("R13 combined write then accrue", rd, 32'h01);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_write_views();
      t_set_clear();
      t_imm();
      t_illegal();
      t_rounding();
      t_accrue();
      t_collide();
      repeat (2) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule